// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

This block derives eight clock outputs, grouped as four sections of two, from a fast tick clock whose period is one time unit. A phase counter walks through N ticks per nominal output period. N is set by a two-bit range select. A second counter spans 4N ticks and feeds the divided waveforms.

Each section reads two three-level selects (F1 and F0), each packed as a 2-bit code. Sections 1 and 2 map the nine code pairs onto a shift of -4 to +4 time units. Sections 3 and 4 map them onto even shifts of up to six units or onto a divided clock. Code HH gives divide-by-4 in section 3 and an inverted zero-shift clock in section 4.

Every output is registered. Any change of a select resets the counters, so the waveforms restart cleanly from phase 0.

Top module: `skew_clk_gen`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs are low after that edge. After release, the k-th rising edge (k = 1, 2, ...) loads the values for tick k-1, counted from tick 0.
- R2: The range select sets N: 00 gives 44, 01 gives 26, 10 gives 16 and 11 gives 26. A zero-shift output is high for ticks 0 to N/2-1 of each N-tick period and low for the rest.
- R3: Level codes are L=00, M=01 and H=10, with idx = 3*level(F1) + level(F0). In sections 1 and 2 the shift is idx-4 time units. A positive shift delays the zero-shift waveform by that many ticks, and a negative shift advances it, modulo N.
- R4: In sections 3 and 4, idx 1 to 7 give a shift of 2*(idx-4) time units, applied as in R3.
- R5: In sections 3 and 4, idx 0 (LL) gives divide-by-2. The period is 2N ticks, and the output is low for the N ticks that start at tick N/2 of the 4N-tick counter, repeating every 2N ticks.
- R6: Code HH (idx 8) gives divide-by-4 in section 3: period 4N, low for the 2N ticks that start at tick N/2. In section 4 it gives the complement of the zero-shift waveform.
- R7: Every falling edge of the divide-by-4 output coincides with a falling edge of the divide-by-2 output.
- R8: Output bits 2s and 2s+1 belong to section s+1 and are always equal. Section s+1 reads its selects from `pair_sel[4s+3:4s+2]` (F1) and `pair_sel[4s+1:4s]` (F0).
- R9: If `range_sel` or `pair_sel` differs from the value held at the previous edge, all outputs are low after the next edge. The edge after that loads tick 0 of the new configuration.
- R10: Code 11 on any select is read as MID. With every select at MID, all eight outputs carry the same zero-shift waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per time unit |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Range select choosing N |
| pair_sel | input | 16 | Per-section F1/F0 select codes, 4 bits per section |
| clk_q | output | 8 | Clock outputs, two per section |

## Verification
Every output is a flop loaded from counters that were themselves cleared one edge earlier. As a result, the value for tick t appears after the (t+1)-th edge that follows reset release or a restart. A select change shows up as all-low outputs after exactly one edge. The bench keeps a behavioural tick count that follows the same edge accounting. It samples two nanoseconds after each rising edge and compares all four sections on every cycle. It also checks, on the cycle where the divide-by-4 output falls, that the divide-by-2 output falls in that same cycle.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {FN_SHIFT, FN_DIV2, FN_DIV4, FN_INV} fn_e;

  // three-level code: 00 low, 10 high, anything else reads as mid
  function automatic int lvl(logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int code_idx(logic [3:0] code);
    return 3 * lvl(code[3:2]) + lvl(code[1:0]);
  endfunction

  function automatic int n_of(logic [1:0] rs, int nl, int nm, int nh);
    case (rs)
      2'b00:   return nl;
      2'b10:   return nh;
      default: return nm;
    endcase
  endfunction

  function automatic fn_e fn_of(logic [3:0] code, bit wide, bit hh_inv);
    int idx;
    idx = code_idx(code);
    if (!wide)          return FN_SHIFT;
    else if (idx == 0)  return FN_DIV2;
    else if (idx == 8)  return hh_inv ? FN_INV : FN_DIV4;
    else                return FN_SHIFT;
  endfunction

  function automatic int shift_of(logic [3:0] code, bit wide);
    return wide ? 2 * (code_idx(code) - 4) : code_idx(code) - 4;
  endfunction

  // nominal waveform sampled k ticks in the past (k may be negative)
  function automatic logic nom_at(int ph, int k, int n);
    int p;
    p = ph + n - k;
    if (p >= n) p -= n;
    if (p >= n) p -= n;
    return (p < n / 2);
  endfunction

  // divided waveforms: both fall where the long counter passes n/2
  function automatic logic div_at(int dc, int n, bit by4);
    int p;
    p = (dc >= n / 2) ? dc - n / 2 : dc + 4 * n - n / 2;
    if (by4) return (p >= 2 * n);
    if (p >= 2 * n) p -= 2 * n;
    return (p >= n);
  endfunction

endpackage

// File: rtl/skew_phase_cnt.sv
module skew_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] n_per,
  output logic [CW-1:0] ph,
  output logic [CW-1:0] dc
);

  logic ph_wrap, dc_wrap;
  assign ph_wrap = (ph == n_per - CW'(1));
  assign dc_wrap = (int'(dc) == 4 * int'(n_per) - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ph <= '0;
      dc <= '0;
    end else begin
      ph <= ph_wrap ? '0 : ph + CW'(1);
      dc <= dc_wrap ? '0 : dc + CW'(1);
    end
  end

  AST_PH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph < n_per);  // R2
  AST_PH_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!restart && ph == n_per - CW'(1)) |=> (ph == '0));  // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ph == '0 && dc == '0));  // R9

endmodule

// File: rtl/skew_div_gen.sv
module skew_div_gen #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] dc,
  input  logic [CW-1:0] n_per,
  output logic          div2_w,
  output logic          div4_w
);
  import skew_pkg::*;

  always_comb begin
    div2_w = div_at(int'(dc), int'(n_per), 1'b0);
    div4_w = div_at(int'(dc), int'(n_per), 1'b1);
  end

endmodule

// File: rtl/skew_section.sv
module skew_section #(
  parameter int CW     = 8,
  parameter bit WIDE   = 1'b0,
  parameter bit HH_INV = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [3:0]    code_q,
  input  logic [CW-1:0] n_per,
  input  logic [CW-1:0] ph,
  input  logic          div2_w,
  input  logic          div4_w,
  output logic          q_a,
  output logic          q_b
);
  import skew_pkg::*;

  fn_e  fn;
  int   k;
  logic nxt;

  always_comb begin
    fn = fn_of(code_q, WIDE, HH_INV);
    k  = (fn == FN_SHIFT) ? shift_of(code_q, WIDE) : 0;
    case (fn)
      FN_DIV2: nxt = div2_w;
      FN_DIV4: nxt = div4_w;
      FN_INV:  nxt = !nom_at(int'(ph), 0, int'(n_per));
      default: nxt = nom_at(int'(ph), k, int'(n_per));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      q_a <= 1'b0;
      q_b <= 1'b0;
    end else begin
      q_a <= nxt;
      q_b <= nxt;
    end
  end

endmodule

// File: rtl/skew_clk_gen.sv
module skew_clk_gen #(
  parameter int NUM_SEC = 4,
  parameter int N_LOW   = 44,
  parameter int N_MID   = 26,
  parameter int N_HIGH  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           range_sel,
  input  logic [4*NUM_SEC-1:0] pair_sel,
  output logic [2*NUM_SEC-1:0] clk_q
);
  import skew_pkg::*;

  localparam int CW = $clog2(4 * N_LOW + 1);
  localparam int SW = 4 * NUM_SEC;

  logic [1:0]    rs_q;
  logic [SW-1:0] sel_q;
  logic          restart;
  logic [CW-1:0] n_cur, ph, dc;
  logic          div2_w, div4_w;

  assign restart = (range_sel != rs_q) || (pair_sel != sel_q);
  assign n_cur   = CW'(n_of(rs_q, N_LOW, N_MID, N_HIGH));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      rs_q  <= range_sel;
      sel_q <= pair_sel;
    end
  end

  skew_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .n_per(n_cur), .ph(ph), .dc(dc)
  );

  skew_div_gen #(.CW(CW)) u_div (
    .dc(dc), .n_per(n_cur), .div2_w(div2_w), .div4_w(div4_w)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic qa, qb;
    skew_section #(
      .CW(CW), .WIDE(bit'(s >= NUM_SEC / 2)), .HH_INV(bit'(s == NUM_SEC - 1))
    ) u_sec (
      .clk(clk), .rst(rst), .restart(restart), .code_q(sel_q[4*s +: 4]),
      .n_per(n_cur), .ph(ph), .div2_w(div2_w), .div4_w(div4_w),
      .q_a(qa), .q_b(qb)
    );
    assign clk_q[2*s]   = qa;
    assign clk_q[2*s+1] = qb;
  end

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
    restart |=> (clk_q == '0));  // R9
  AST_DIV_FALL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $fell(div4_w) |-> $fell(div2_w));  // R7

endmodule

// File: tb/skew_clk_gen_tb.sv
`timescale 1ns/1ps
module skew_clk_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rs  = 2'b01;
  logic [15:0] sel = 16'h5555;
  logic [7:0]  q;
  int checks = 0, errors = 0;
  bit chk_on = 1'b0;

  always #2.5 clk = ~clk;

  skew_clk_gen u_dut (.clk(clk), .rst(rst), .range_sel(rs), .pair_sel(sel), .clk_q(q));

  function automatic int lv(logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic int per(logic [1:0] r);
    return (r == 2'b00) ? 44 : (r == 2'b10) ? 16 : 26;
  endfunction

  function automatic logic [3:0] enc(int idx);
    logic [1:0] a, b;
    a = (idx / 3 == 0) ? 2'b00 : (idx / 3 == 1) ? 2'b01 : 2'b10;
    b = (idx % 3 == 0) ? 2'b00 : (idx % 3 == 1) ? 2'b01 : 2'b10;
    return {a, b};
  endfunction

  function automatic bit hi_at(int x, int n);
    return (((x % n) + n) % n) < n / 2;
  endfunction

  // expected level of section s at tick t
  function automatic bit expect_bit(int s, int t, logic [1:0] r, logic [3:0] c);
    int n, idx, m;
    n = per(r);
    idx = 3 * lv(c[3:2]) + lv(c[1:0]);
    if (s < 2) return hi_at(t - (idx - 4), n);
    if (idx == 0) begin
      m = 2 * n;
      return (((t - n / 2) % m + m) % m) >= n;
    end
    if (idx == 8 && s == 2) begin
      m = 4 * n;
      return (((t - n / 2) % m + m) % m) >= 2 * n;
    end
    if (idx == 8) return !hi_at(t, n);
    return hi_at(t - 2 * (idx - 4), n);
  endfunction

  function automatic string tag_of(int s, logic [3:0] c);
    int idx;
    idx = 3 * lv(c[3:2]) + lv(c[1:0]);
    if (c[3:2] == 2'b11 || c[1:0] == 2'b11) return "R10";
    if (s < 2) return (idx == 4) ? "R2" : "R3";
    if (idx == 0) return "R5";
    if (idx == 8) return "R6";
    return "R4";
  endfunction

  // behavioural reference
  int          m_t;
  logic [7:0]  m_q;
  logic [1:0]  m_rs;
  logic [15:0] m_sel;

  always @(posedge clk) begin
    if (rst || rs != m_rs || sel != m_sel) begin
      m_t <= 0; m_q <= '0; m_rs <= rs; m_sel <= sel;
    end else begin
      for (int s = 0; s < 4; s++) begin
        m_q[2*s]   <= expect_bit(s, m_t, m_rs, m_sel[4*s +: 4]);
        m_q[2*s+1] <= expect_bit(s, m_t, m_rs, m_sel[4*s +: 4]);
      end
      m_t <= m_t + 1;
    end
  end

  task automatic check(bit ok, string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  logic [7:0] prev_q;
  always @(posedge clk) begin
    #2;
    if (chk_on && !rst) begin
      for (int s = 0; s < 4; s++) begin
        check(q[2*s] === m_q[2*s], tag_of(s, m_sel[4*s +: 4]), q, m_q);
        check(q[2*s] === q[2*s+1], "R8", q, m_q);
      end
      // divide-by-4 in section 3 and divide-by-2 in section 4: shared falling edge
      if (m_t >= 2 && m_sel[11:8] == 4'b1010 && m_sel[15:12] == 4'b0000 &&
          prev_q[4] && !q[4])
        check(prev_q[6] && !q[6], "R7", q, {1'b0, prev_q[6], 6'b0});
    end
    prev_q = q;
  end

  task automatic apply(logic [1:0] r, logic [15:0] c, int cyc);
    @(negedge clk);
    rs = r; sel = c;
    @(posedge clk); #2;
    check(q == 8'h00, "R9", q, 8'h00);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(q == 8'h00, "R1", q, 8'h00);
    rst = 1'b0;
    chk_on = 1'b1;
    @(posedge clk); #2;
    check(q == 8'hFF, "R1", q, 8'hFF);   // tick 0 of all-MID: all high
    repeat (120) @(negedge clk);
    for (int i = 0; i < 9; i++)
      apply(2'(i % 3 == 0 ? 0 : (i % 3 == 1 ? 1 : 2)),
            {enc(i), enc((i + 3) % 9), enc((i + 5) % 9), enc(i)}, 200);
    apply(2'b10, {4'b0000, 4'b1010, 4'b0101, 4'b0101}, 150);
    apply(2'b00, {4'b0000, 4'b1010, 4'b0010, 4'b1000}, 380);
    apply(2'b11, 16'hFFFF, 120);
    apply(2'b01, 16'b1101_0111_0011_1110, 240);
    apply(2'b01, {4'b1010, 4'b0111, 4'b1001, 4'b0001}, 120);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(q == 8'h00, "R1", q, 8'h00);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule